// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block terminates message-signalled interrupt writes. Each vector is named by two things at once. The write address picks one of 16 termination groups and one of 8 index registers inside that group. The write data value picks one of the 16 pending bits inside that register. A posting write sets that bit. The 2048 pending bits (16 × 8 × 16) are held until software reads the index register. That read returns the pending bits and clears them in the same access.

Each group also has a read-only summary word. Bit x of that word shows whether index register x of the group holds anything. Each group drives one interrupt line, which is high while any bit in the group is pending. A handler follows the interrupt line to the group's summary word, then reads the flagged index registers. Each of those reads consumes the bits it returns.

There are two access ports: a write channel that posts vectors, and a read channel that returns state one cycle after the request. Because the channels are separate, a posting write and a consuming read can land on the same register in the same cycle.

Top module: `msi_term_bank`

## Requirements
- R1: An address with bit 23 = 0 selects an index register: bits [22:19] give the group (0..15), bits [18:16] give the index (0..7), and bits [15:0] are ignored.
- R2: A write to an index register with a data value v in 0..15 sets pending bit v of that register and leaves its other bits unchanged.
- R3: A write is ignored when its data value is above 15 (any of data bits [31:4] set). A write to a summary address or to an unmapped address is also ignored.
- R4: A read of an index register returns its 16 bits in rd_data[15:0], with rd_data[31:16] = 0, in the cycle after the request. The register is cleared to zero by that read.
- R5: A write and a read that hit the same index register in the same cycle interact as follows. The read returns the contents from before the write. The newly posted bit stays set after the clear.
- R6: An address with bit 23 = 1 and bits [22:20] = 0 selects the summary word of group bits [19:16]. In that word, bit x = 1 exactly when index register x of the group is nonzero, and bits [31:8] = 0. Reading a summary word changes no state.
- R7: irq_out[g] is high exactly when group g holds any pending bit. It follows the register state in the cycle after the edge that changed it.
- R8: A read of an unmapped address (bit 23 = 1 with bits [22:20] nonzero) returns zero.
- R9: Reset clears every pending bit, drives irq_out to zero and drives rd_valid low.
- R10: rd_valid is high in exactly the cycles that follow a cycle with rd_en high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Posting write request, single beat |
| wr_addr | input | 24 | Write byte offset |
| wr_data | input | 32 | Write data; its value is the bit number to post |
| rd_en | input | 1 | Read request, single beat |
| rd_addr | input | 24 | Read byte offset |
| rd_data | output | 32 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result strobe, one cycle after rd_en |
| irq_out | output | 16 | Per-group pending interrupt lines |

## Verification
The directed patterns each separate one behaviour from its neighbours:
- Two posts to one register: tells OR-accumulation (R2) from overwrite.
- A read repeated back to back: tells read-to-clear (R4) from a plain read.
- A write and a read on the same register in one cycle: tells the survival order (R5) from a clear that wins.
- Addresses with the low offset bits set: show that those bits are ignored (R1).
- Out-of-range data values, and writes to summary or unmapped space: show that nothing changes (R3).

Random traffic follows the directed patterns. It mixes index, summary and unmapped addresses with mostly in-range data values. This produces collisions between the two channels across all groups. It also checks every summary word and interrupt line against a reference model computed each cycle.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;

    // Defaults shared by the bank, its decoder and its checker
    localparam int unsigned DEF_GROUPS  = 16;
    localparam int unsigned DEF_INDICES = 8;
    localparam int unsigned DEF_BITS    = 16;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_STRIDE  = 16;   // log2 of the register spacing

    typedef enum logic [1:0] {
        REGION_NONE    = 2'd0,
        REGION_INDEX   = 2'd1,
        REGION_SUMMARY = 2'd2
    } region_e;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_term_pkg::*;
#(
    parameter int unsigned GRP_W  = 4,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned STRIDE = 16,
    localparam int unsigned ADDR_W = STRIDE + IDX_W + GRP_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [GRP_W-1:0]  grp,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned TOP    = ADDR_W - 1;
    localparam int unsigned GRP_LO = STRIDE + IDX_W;
    localparam int unsigned PAD_LO = STRIDE + GRP_W;

    // Offset bits inside one register slot carry no meaning
    logic unused_low;
    assign unused_low = ^addr[STRIDE-1:0];

    always_comb begin
        region = REGION_NONE;
        grp    = '0;
        idx    = '0;
        if (!addr[TOP]) begin
            region = REGION_INDEX;
            grp    = addr[GRP_LO +: GRP_W];
            idx    = addr[STRIDE +: IDX_W];
        end else if (addr[TOP-1:PAD_LO] == '0) begin
            region = REGION_SUMMARY;
            grp    = addr[STRIDE +: GRP_W];
        end
    end

endmodule

// File: rtl/msi_group.sv
module msi_group #(
    parameter int unsigned N_IDX  = 8,
    parameter int unsigned N_BITS = 16,
    localparam int unsigned IDX_W = $clog2(N_IDX),
    localparam int unsigned BIT_W = $clog2(N_BITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_en,
    input  logic [IDX_W-1:0]              set_idx,
    input  logic [BIT_W-1:0]              set_bit,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    output logic [N_IDX-1:0][N_BITS-1:0]  pend,
    output logic [N_IDX-1:0]              summary,
    output logic                          irq
);

    typedef struct packed {
        logic [N_IDX-1:0][N_BITS-1:0] pend;
    } grp_state_t;

    grp_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Clear first so that a bit posted in the same cycle is kept
        if (clr_en) begin
            state_d.pend[clr_idx] = '0;
        end
        if (set_en) begin
            state_d.pend[set_idx][set_bit] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar i = 0; i < N_IDX; i++) begin : g_sum
        assign summary[i] = |state_q.pend[i];
    end

    assign pend = state_q.pend;
    assign irq  = |summary;

endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
    import msi_term_pkg::*;
#(
    parameter int unsigned N_GROUPS = DEF_GROUPS,
    parameter int unsigned N_IDX    = DEF_INDICES,
    parameter int unsigned N_BITS   = DEF_BITS,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    parameter int unsigned STRIDE   = DEF_STRIDE,
    localparam int unsigned GRP_W   = $clog2(N_GROUPS),
    localparam int unsigned IDX_W   = $clog2(N_IDX),
    localparam int unsigned BIT_W   = $clog2(N_BITS),
    localparam int unsigned ADDR_W  = STRIDE + IDX_W + GRP_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [N_GROUPS-1:0]  irq_out
);

    region_e             wr_region, rd_region;
    logic [GRP_W-1:0]    wr_grp, rd_grp;
    logic [IDX_W-1:0]    wr_idx, rd_idx;

    msi_addr_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .STRIDE(STRIDE)) u_wr_dec (
        .addr   (wr_addr),
        .region (wr_region),
        .grp    (wr_grp),
        .idx    (wr_idx)
    );

    msi_addr_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .STRIDE(STRIDE)) u_rd_dec (
        .addr   (rd_addr),
        .region (rd_region),
        .grp    (rd_grp),
        .idx    (rd_idx)
    );

    // A post is accepted only for an index register and an in-range bit number
    logic data_in_range;
    logic post_ok;
    logic consume_ok;

    assign data_in_range = (wr_data[DATA_W-1:BIT_W] == '0);
    assign post_ok       = wr_en && (wr_region == REGION_INDEX) && data_in_range;
    assign consume_ok    = rd_en && (rd_region == REGION_INDEX);

    logic [N_GROUPS-1:0][N_IDX-1:0][N_BITS-1:0] pend_all;
    logic [N_GROUPS-1:0][N_IDX-1:0]             summ_all;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        msi_group #(.N_IDX(N_IDX), .N_BITS(N_BITS)) u_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (post_ok && (wr_grp == GRP_W'(g))),
            .set_idx (wr_idx),
            .set_bit (wr_data[BIT_W-1:0]),
            .clr_en  (consume_ok && (rd_grp == GRP_W'(g))),
            .clr_idx (rd_idx),
            .pend    (pend_all[g]),
            .summary (summ_all[g]),
            .irq     (irq_out[g])
        );
    end

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        unique case (rd_region)
            REGION_INDEX:   rd_word = DATA_W'(pend_all[rd_grp][rd_idx]);
            REGION_SUMMARY: rd_word = DATA_W'(summ_all[rd_grp]);
            default:        rd_word = '0;
        endcase

        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) begin
            rd_d.data = rd_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

endmodule

// File: rtl/msi_term_bank_chk.sv
module msi_term_bank_chk #(
    parameter int unsigned N_GROUPS = 16,
    parameter int unsigned N_IDX    = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned STRIDE   = 16,
    parameter int unsigned GRP_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic                rd_en,
    input logic [DATA_W-1:0]   rd_data,
    input logic                rd_valid,
    input logic [N_GROUPS-1:0] irq_out
);

    localparam int unsigned TOP    = ADDR_W - 1;
    localparam int unsigned PAD_LO = STRIDE + GRP_W;

    logic hit_summary, hit_unmapped;
    assign hit_summary  = rd_addr[TOP] && (rd_addr[TOP-1:PAD_LO] == '0);
    assign hit_unmapped = rd_addr[TOP] && (rd_addr[TOP-1:PAD_LO] != '0);

    // R10
    a_r10_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R8
    a_r8_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_unmapped) |=> (rd_data == '0));
    // R6
    a_r6_summary_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_summary) |=> (rd_data[DATA_W-1:N_IDX] == '0));
    a_r6_summary_read_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_summary && !wr_en) |=> $stable(irq_out));
    // R7: a line can only rise after a posting write
    a_r7_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~$past(irq_out)) != '0) |-> $past(wr_en));
    // R4: a line can only fall after a consuming read
    a_r4_fall_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq_out & $past(irq_out)) != '0) |-> $past(rd_en));

endmodule

bind msi_term_bank msi_term_bank_chk #(
    .N_GROUPS (N_GROUPS),
    .N_IDX    (N_IDX),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .STRIDE   (STRIDE),
    .GRP_W    (GRP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_addr  (rd_addr),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .irq_out  (irq_out)
);

// File: tb/msi_term_bank_bench.sv
`timescale 1ns/1ps
module msi_term_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [15:0] irq_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done  = 0;

    logic [15:0] mdl [16][8];

    always #5 clk = ~clk;

    msi_term_bank u_msi_term_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .irq_out  (irq_out)
    );

    function automatic logic [23:0] idx_addr(int g, int i, logic [15:0] low);
        return {1'b0, 4'(g), 3'(i), low};
    endfunction

    function automatic logic [23:0] sum_addr(int g);
        return {1'b1, 3'b000, 4'(g), 16'h0000};
    endfunction

    function automatic logic [31:0] exp_read(logic [23:0] a);
        logic [31:0] v = '0;
        if (!a[23]) begin
            v = {16'h0, mdl[a[22:19]][a[18:16]]};
        end else if (a[22:20] == 3'b000) begin
            for (int i = 0; i < 8; i++) v[i] = (mdl[a[19:16]][i] != 16'h0);
        end
        return v;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] r = '0;
        for (int g = 0; g < 16; g++)
            for (int i = 0; i < 8; i++)
                if (mdl[g][i] != 16'h0) r[g] = 1'b1;
        return r;
    endfunction

    task automatic clear_model();
        for (int g = 0; g < 16; g++)
            for (int i = 0; i < 8; i++) mdl[g][i] = '0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one cycle of traffic just after a falling edge and checks the
    // outputs at the next falling edge.
    task automatic step(input logic we, input logic [23:0] wa, input logic [31:0] wd,
                        input logic re, input logic [23:0] ra, input string req);
        logic [31:0] e;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        e = exp_read(ra);
        if (re && !ra[23]) mdl[ra[22:19]][ra[18:16]] = '0;
        if (we && !wa[23] && wd < 32'd16) mdl[wa[22:19]][wa[18:16]][wd[3:0]] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (re) begin
            check({req, " R10 valid"}, {31'h0, rd_valid}, 32'h1);
            check({req, " data"}, rd_data, e);
        end else begin
            check({req, " R10 idle"}, {31'h0, rd_valid}, 32'h0);
        end
        check({req, " R7 irq"}, {16'h0, irq_out}, {16'h0, exp_irq()});
    endtask

    task automatic post(int g, int i, logic [31:0] d, string req);
        step(1'b1, idx_addr(g, i, 16'h0), d, 1'b0, '0, req);
    endtask

    task automatic fetch(logic [23:0] a, string req);
        step(1'b0, '0, '0, 1'b1, a, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        clear_model();
        repeat (3) @(negedge clk);
        check("R9 reset irq", {16'h0, irq_out}, 32'h0);
        check("R9 reset valid", {31'h0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        fetch(idx_addr(0, 0, 16'h0), "R9 empty after reset");
        fetch(sum_addr(9), "R9 summary empty");

        // R2 accumulate, R4 read then clear
        post(3, 5, 32'd7, "R2 first post");
        post(3, 5, 32'd0, "R2 second post");
        fetch(idx_addr(3, 5, 16'h0), "R4 read 0x81");
        fetch(idx_addr(3, 5, 16'h0), "R4 reread zero");

        // R1 low offset bits ignored, top group and index
        step(1'b1, idx_addr(15, 7, 16'hABCD), 32'd15, 1'b0, '0, "R1 post with low bits");
        fetch(sum_addr(15), "R6 summary bit 7");
        fetch(idx_addr(15, 7, 16'h1234), "R1 read with other low bits");

        // R3 ignored writes
        post(2, 1, 32'd16, "R3 data 16");
        post(2, 1, 32'h8000_0003, "R3 high data bit");
        step(1'b1, sum_addr(2), 32'd1, 1'b0, '0, "R3 write to summary");
        step(1'b1, 24'hA2_0000, 32'd2, 1'b0, '0, "R3 write unmapped");
        fetch(idx_addr(2, 1, 16'h0), "R3 register untouched");
        fetch(sum_addr(2), "R3 summary untouched");

        // R5 same-cycle post and consume
        post(4, 2, 32'd1, "R5 preload");
        step(1'b1, idx_addr(4, 2, 16'h0), 32'd9, 1'b1, idx_addr(4, 2, 16'h0), "R5 collide returns old");
        fetch(idx_addr(4, 2, 16'h0), "R5 new bit survived");

        // R8 unmapped reads, R6 summary read keeps state
        post(6, 0, 32'd3, "R6 setup");
        fetch(24'hF0_0000, "R8 unmapped read");
        fetch(sum_addr(6), "R6 summary read 1");
        fetch(sum_addr(6), "R6 summary read 2");
        fetch(idx_addr(6, 0, 16'h0), "R6 state kept");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int unsigned sel;
            sel = $urandom % 20;
            if (sel < 14) a = idx_addr($urandom % 16, $urandom % 8, 16'($urandom));
            else if (sel < 17) a = sum_addr($urandom % 16);
            else a = {1'b1, 3'(1 + $urandom % 7), 20'($urandom)};
            d = ($urandom % 10 < 9) ? 32'($urandom % 16) : 32'($urandom);
            step(($urandom % 3) != 0, a, d, ($urandom % 2) != 0,
                 ($urandom % 4 == 0) ? a : idx_addr($urandom % 16, $urandom % 8, 16'h0),
                 "R2 R4 R6 random");
        end

        // R9 reset in the middle of traffic
        post(11, 3, 32'd5, "R9 preload");
        rst_n = 1'b0;
        @(negedge clk);
        clear_model();
        check("R9 mid reset irq", {16'h0, irq_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        fetch(idx_addr(11, 3, 16'h0), "R9 cleared by reset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule